// File: doc/BRIEF.md
# Transmit Channel Signaling Inserter

This block writes per-channel signaling bits into an outgoing T1 or E1 framed bit stream. A host port loads a bank of sixteen 8-bit signaling registers. Each register carries the 4-bit signaling words of two channels. The stream side supplies one bit per `bit_vld` cycle, together with the bit's position: frame number, timeslot or channel number, bit number within the byte, a framing-bit marker and a multiframe-start marker. The block returns the same stream one accepted bit later. At the signaling positions, the bits are replaced by values taken from an internal copy of the register bank.

The internal copy is refreshed only at multiframe boundaries. The host can therefore rewrite registers at any time without tearing a multiframe that is in flight. A multiframe flag tells the host when a boundary has passed. In T1 the signaling rides in the least significant bit of each channel byte in the signaling frames. In E1 it fills timeslot 16 of frames 1 to 15.

In D4 superframing only A and B are carried per channel. Because of this, one register load serves two superframes, and the copy is refreshed on every second D4 boundary.

Top module: `tx_sig_inserter`

## Requirements
- R1: After reset, `ser_out` is 0, `mf_irq` is 0, and the first multiframe boundary reloads the internal copy in every mode.
- R2: A host write changes the internal copy only at a reloading multiframe boundary (a `bit_vld` cycle with `mf_start`). Writes made inside a multiframe do not alter the bits inserted in that multiframe.
- R3: In T1 ESF mode (`t1_mode`=1, `esf_mode`=1), channel c (0..23) uses register c/2. Even channels use bits 7:4 of that register and odd channels use bits 3:0. The nibble bit 3 is A, bit 2 is B, bit 1 is C and bit 0 is D. A, B, C and D replace bit 7 (the last bit of the channel byte) in frames 6, 12, 18 and 24, with frames numbered 1..24.
- R4: In T1 D4 mode (`esf_mode`=0, frames 1..12), frames 6 and 12 carry A and B. In the first superframe after a reload, A and B come from nibble bits 3 and 2. In the following superframe they come from nibble bits 1 and 0.
- R5: In D4 mode the internal copy is reloaded on every second superframe boundary only. Host writes made during the first superframe of a pair appear after the second boundary, not the first.
- R6: In E1 mode (`t1_mode`=0), timeslot 16 of frame f (1..15) is filled from register f. Bits 0..3 of the timeslot carry channel f and bits 4..7 carry channel f+15. Timeslot bit k carries register bit 7-k. Frame 0 and all other timeslots pass through unchanged.
- R7: When the enable for the active line mode (`t1_ins_en` in T1, `e1_ins_en` in E1) is 0, `ser_out` reproduces `ser_in` at every position.
- R8: A channel whose bit in `chan_ins_mask` is 0 keeps its incoming signaling bits. The mask index is c for T1 channel c, and f or f+15 for the E1 channel numbers.
- R9: `mf_irq` rises after every multiframe boundary, including a D4 boundary that does not reload. A cycle with `irq_clr`=1 clears it, but a boundary in the same cycle wins.
- R10: `ser_out` presents each accepted bit exactly one `bit_vld` cycle later and holds while `bit_vld` is 0. Framing bits (`fbit`) and every position that is not a signaling position pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_addr | input | 4 | Host register index |
| host_wr_data | input | 8 | Host write data, two 4-bit signaling words |
| irq_clr | input | 1 | Write-one-to-clear for the multiframe flag |
| t1_mode | input | 1 | 1 = T1 line, 0 = E1 line |
| esf_mode | input | 1 | T1 only: 1 = ESF, 0 = D4 |
| t1_ins_en | input | 1 | Global insertion enable used in T1 |
| e1_ins_en | input | 1 | Global insertion enable used in E1 |
| chan_ins_mask | input | 32 | Per-channel insertion enables |
| bit_vld | input | 1 | A stream bit is present this cycle |
| ser_in | input | 1 | Incoming stream bit |
| fbit | input | 1 | Current bit is a T1 framing bit |
| mf_start | input | 1 | Current bit is the first bit of a multiframe |
| frame_num | input | 5 | Frame number (T1 1..24, E1 0..15) |
| ts_num | input | 5 | T1 channel 0..23 or E1 timeslot 0..31 |
| bit_num | input | 3 | Bit within the byte, 0 sent first |
| ser_out | output | 1 | Outgoing stream bit |
| mf_irq | output | 1 | Multiframe boundary flag |

## Verification
The hardest situation to reach is the D4 superframe that does not reload. There the output must still come from the old load, now using its C/D nibble bits, while the bank already holds newer values. The bench rewrites registers in the middle of every superframe over four consecutive D4 superframes. This exposes both a reload that happens too early and a phase that is selected wrongly. Frames 18 and 24 are never presented in D4. The bench also inserts idle cycles in the middle of frames and clears the flag in every multiframe, so that both the skipped boundary and the hold behaviour are observed at the ports.

// File: rtl/sig_ins_pkg.sv
package sig_ins_pkg;
  localparam int NUM_REGS  = 16;
  localparam int REG_W     = 8;
  localparam int NIB_W     = REG_W / 2;
  localparam int MASK_W    = 32;
  localparam int POS_W     = 5;
  localparam int BIT_W     = 3;
  localparam int REG_AW    = $clog2(NUM_REGS);
  localparam int T1_CHANS  = 24;
  localparam int E1_FRAMES = 16;

  typedef logic [REG_W-1:0] sig_byte_t;
  typedef logic [NUM_REGS-1:0][REG_W-1:0] sig_bank_t;
endpackage

// File: rtl/sig_reg_bank.sv
module sig_reg_bank
  import sig_ins_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  sig_byte_t         wr_data,
  input  logic              reload,
  output sig_bank_t         shadow
);
  sig_bank_t host_q;
  sig_bank_t host_d;
  sig_bank_t shadow_q;
  sig_bank_t shadow_d;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_comb begin
      host_d[g] = host_q[g];
      if (wr_en && (wr_addr == REG_AW'(g))) host_d[g] = wr_data;
      shadow_d[g] = reload ? host_q[g] : shadow_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        host_q[g]   <= '0;
        shadow_q[g] <= '0;
      end else begin
        host_q[g]   <= host_d[g];
        shadow_q[g] <= shadow_d[g];
      end
    end
  end

  assign shadow = shadow_q;
endmodule

// File: rtl/sig_mf_ctrl.sv
module sig_mf_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic mf_start,
  input  logic t1_mode,
  input  logic esf_mode,
  input  logic irq_clr,
  output logic reload,
  output logic d4_second,
  output logic mf_irq
);
  logic mf_tick;
  logic d4_mode;
  logic second_q, second_d;
  logic irq_q, irq_d;

  assign mf_tick = bit_vld & mf_start;
  assign d4_mode = t1_mode & ~esf_mode;
  assign reload  = mf_tick & (~d4_mode | second_q);

  always_comb begin
    second_d = second_q;
    if (mf_tick) second_d = ~reload;
    irq_d = irq_q;
    if (irq_clr) irq_d = 1'b0;
    if (mf_tick) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_q <= 1'b1;
      irq_q    <= 1'b0;
    end else begin
      second_q <= second_d;
      irq_q    <= irq_d;
    end
  end

  assign d4_second = second_q;
  assign mf_irq    = irq_q;
endmodule

// File: rtl/sig_bit_pick.sv
module sig_bit_pick
  import sig_ins_pkg::*;
(
  input  sig_bank_t         shadow,
  input  logic              t1_mode,
  input  logic              esf_mode,
  input  logic              t1_ins_en,
  input  logic              e1_ins_en,
  input  logic [MASK_W-1:0] chan_mask,
  input  logic              d4_second,
  input  logic              fbit,
  input  logic [POS_W-1:0]  frame_num,
  input  logic [POS_W-1:0]  ts_num,
  input  logic [BIT_W-1:0]  bit_num,
  input  logic              ser_in,
  output logic              bit_out
);
  sig_byte_t        t1_byte;
  sig_byte_t        e1_byte;
  logic [NIB_W-1:0] t1_nib;
  logic [1:0]       t1_sel;
  logic             t1_slot;
  logic             t1_hit;
  logic             e1_hit;
  logic [POS_W-1:0] e1_chan;

  always_comb begin
    t1_byte = shadow[REG_AW'(ts_num >> 1)];
    t1_nib  = ts_num[0] ? t1_byte[NIB_W-1:0] : t1_byte[REG_W-1:NIB_W];
    t1_slot = 1'b0;
    t1_sel  = 2'd0;
    if (esf_mode) begin
      unique case (frame_num)
        5'd6:    begin t1_slot = 1'b1; t1_sel = 2'd3; end
        5'd12:   begin t1_slot = 1'b1; t1_sel = 2'd2; end
        5'd18:   begin t1_slot = 1'b1; t1_sel = 2'd1; end
        5'd24:   begin t1_slot = 1'b1; t1_sel = 2'd0; end
        default: begin t1_slot = 1'b0; t1_sel = 2'd0; end
      endcase
    end else begin
      unique case (frame_num)
        5'd6:    begin t1_slot = 1'b1; t1_sel = d4_second ? 2'd1 : 2'd3; end
        5'd12:   begin t1_slot = 1'b1; t1_sel = d4_second ? 2'd0 : 2'd2; end
        default: begin t1_slot = 1'b0; t1_sel = 2'd0; end
      endcase
    end
    t1_hit = t1_mode && t1_ins_en && !fbit && t1_slot &&
             (bit_num == 3'd7) && (ts_num < POS_W'(T1_CHANS)) && chan_mask[ts_num];

    e1_byte = shadow[REG_AW'(frame_num)];
    e1_chan = bit_num[2] ? (frame_num + POS_W'(15)) : frame_num;
    e1_hit  = !t1_mode && e1_ins_en && (ts_num == POS_W'(16)) &&
              (frame_num != '0) && (frame_num < POS_W'(E1_FRAMES)) && chan_mask[e1_chan];

    bit_out = ser_in;
    if (t1_hit)      bit_out = t1_nib[t1_sel];
    else if (e1_hit) bit_out = e1_byte[BIT_W'(3'd7 - bit_num)];
  end
endmodule

// File: rtl/tx_sig_inserter.sv
module tx_sig_inserter
  import sig_ins_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [3:0]        host_wr_addr,
  input  logic [7:0]        host_wr_data,
  input  logic              irq_clr,
  input  logic              t1_mode,
  input  logic              esf_mode,
  input  logic              t1_ins_en,
  input  logic              e1_ins_en,
  input  logic [31:0]       chan_ins_mask,
  input  logic              bit_vld,
  input  logic              ser_in,
  input  logic              fbit,
  input  logic              mf_start,
  input  logic [4:0]        frame_num,
  input  logic [4:0]        ts_num,
  input  logic [2:0]        bit_num,
  output logic              ser_out,
  output logic              mf_irq
);
  logic [1:0] rst_pipe_q;
  logic       rst_s_n;
  logic       reload_w;
  logic       d4_second_w;
  logic       pick_w;
  logic       out_q, out_d;
  sig_bank_t  shadow_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  sig_reg_bank bank_i (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_en   (host_wr_en),
    .wr_addr (host_wr_addr),
    .wr_data (host_wr_data),
    .reload  (reload_w),
    .shadow  (shadow_w)
  );

  sig_mf_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .bit_vld   (bit_vld),
    .mf_start  (mf_start),
    .t1_mode   (t1_mode),
    .esf_mode  (esf_mode),
    .irq_clr   (irq_clr),
    .reload    (reload_w),
    .d4_second (d4_second_w),
    .mf_irq    (mf_irq)
  );

  sig_bit_pick pick_i (
    .shadow    (shadow_w),
    .t1_mode   (t1_mode),
    .esf_mode  (esf_mode),
    .t1_ins_en (t1_ins_en),
    .e1_ins_en (e1_ins_en),
    .chan_mask (chan_ins_mask),
    .d4_second (d4_second_w),
    .fbit      (fbit),
    .frame_num (frame_num),
    .ts_num    (ts_num),
    .bit_num   (bit_num),
    .ser_in    (ser_in),
    .bit_out   (pick_w)
  );

  always_comb begin
    out_d = out_q;
    if (bit_vld) out_d = pick_w;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) out_q <= 1'b0;
    else          out_q <= out_d;
  end

  assign ser_out = out_q;
endmodule

// File: rtl/sig_ins_chk.sv
module sig_ins_chk
  import sig_ins_pkg::*;
(
  input logic      clk,
  input logic      rst_s_n,
  input logic      bit_vld,
  input logic      mf_start,
  input logic      irq_clr,
  input logic      fbit,
  input logic      t1_mode,
  input logic      t1_ins_en,
  input logic      e1_ins_en,
  input logic      ser_in,
  input logic      ser_out,
  input logic      mf_irq,
  input logic      reload,
  input sig_bank_t shadow
);
  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bit_vld && mf_start) |=> mf_irq);
  // R9
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (irq_clr && !(bit_vld && mf_start)) |=> !mf_irq);
  // R2
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !reload |=> $stable(shadow));
  // R2
  reload_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    reload |-> (bit_vld && mf_start));
  // R7
  t1_pass_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bit_vld && t1_mode && !t1_ins_en) |=> (ser_out == $past(ser_in)));
  // R7
  e1_pass_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bit_vld && !t1_mode && !e1_ins_en) |=> (ser_out == $past(ser_in)));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !bit_vld |=> $stable(ser_out));
  // R10
  fbit_pass_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bit_vld && fbit) |=> (ser_out == $past(ser_in)));
endmodule

bind tx_sig_inserter sig_ins_chk chk_i (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .bit_vld   (bit_vld),
  .mf_start  (mf_start),
  .irq_clr   (irq_clr),
  .fbit      (fbit),
  .t1_mode   (t1_mode),
  .t1_ins_en (t1_ins_en),
  .e1_ins_en (e1_ins_en),
  .ser_in    (ser_in),
  .ser_out   (ser_out),
  .mf_irq    (mf_irq),
  .reload    (reload_w),
  .shadow    (shadow_w)
);

// File: tb/tx_sig_inserter_tb.sv
module tx_sig_inserter_tb_top;
  logic        clk;
  logic        rst_n;
  logic        host_wr_en;
  logic [3:0]  host_wr_addr;
  logic [7:0]  host_wr_data;
  logic        irq_clr;
  logic        t1_mode;
  logic        esf_mode;
  logic        t1_ins_en;
  logic        e1_ins_en;
  logic [31:0] chan_ins_mask;
  logic        bit_vld;
  logic        ser_in;
  logic        fbit;
  logic        mf_start;
  logic [4:0]  frame_num;
  logic [4:0]  ts_num;
  logic [2:0]  bit_num;
  logic        ser_out;
  logic        mf_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  logic [7:0] m_bank [16];
  logic [7:0] m_buf  [16];
  bit         m_second;
  bit         pend;
  logic       exp_q;
  string      tag_q;
  int         seed;

  tx_sig_inserter dut_i (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mkval(input int s, input int k);
    return 8'((s * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic host_write_idle(input int k, input logic [7:0] v);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_addr = 4'(k); host_wr_data = v; bit_vld = 1'b0;
    m_bank[k] = v;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  function automatic void model(input logic sin, input int fr, input int ts, input int bt,
                                input bit fb, output logic e, output string tag);
    int idx;
    int ch;
    logic [7:0] b;
    logic [3:0] nib;
    e = sin; tag = "R10"; idx = -1;
    if (t1_mode) begin
      if (!fb && bt == 7 && ts < 24) begin
        if (esf_mode) idx = (fr == 6) ? 3 : (fr == 12) ? 2 : (fr == 18) ? 1 : (fr == 24) ? 0 : -1;
        else          idx = (fr == 6) ? (m_second ? 1 : 3) : (fr == 12) ? (m_second ? 0 : 2) : -1;
        if (idx >= 0) begin
          if (!t1_ins_en) tag = "R7";
          else if (!chan_ins_mask[ts]) tag = "R8";
          else begin
            b = m_buf[ts / 2];
            nib = (ts % 2) ? b[3:0] : b[7:4];
            e = nib[idx];
            tag = (m_buf[ts / 2] != m_bank[ts / 2]) ? "R2" :
                  esf_mode ? "R3" : (m_second ? "R5" : "R4");
          end
        end
      end
    end else if (ts == 16 && fr >= 1 && fr <= 15) begin
      ch = (bt < 4) ? fr : fr + 15;
      if (!e1_ins_en) tag = "R7";
      else if (!chan_ins_mask[ch]) tag = "R8";
      else begin
        b = m_buf[fr];
        e = b[7 - bt];
        tag = (m_buf[fr] != m_bank[fr]) ? "R2" : "R6";
      end
    end
  endfunction

  task automatic drive_bit(input int fr, input int ts, input int bt, input bit fb,
                           input bit mfs, input int pos, input bit rewrite);
    logic e;
    string t;
    logic sin;
    bit rl;
    if (pos == 50) begin
      @(negedge clk);
      if (pend) check(ser_out == exp_q, tag_q, ser_out, exp_q);
      bit_vld = 1'b0; host_wr_en = 1'b0; irq_clr = 1'b0;
    end
    @(negedge clk);
    if (pend) check(ser_out == exp_q, (pos == 50) ? "R10" : tag_q, ser_out, exp_q);
    host_wr_en = 1'b0;
    irq_clr = 1'b0;
    if (fr == 2 && pos == 0) begin
      check(mf_irq == 1'b1, "R9", mf_irq, 1);
      irq_clr = 1'b1;
    end
    if (fr == 2 && pos == 2) check(mf_irq == 1'b0, "R9", mf_irq, 0);
    if (rewrite && fr == 3 && pos < 16) begin
      host_wr_en = 1'b1; host_wr_addr = 4'(pos);
      host_wr_data = mkval(seed, pos);
    end
    sin = 1'((fr * 7 + ts * 3 + bt * 5 + seed) % 3 == 0);
    bit_vld = 1'b1; ser_in = sin; fbit = fb; mf_start = mfs;
    frame_num = 5'(fr); ts_num = 5'(ts); bit_num = 3'(bt);
    model(sin, fr, ts, bt, fb, e, t);
    if (mfs) begin
      rl = !(t1_mode && !esf_mode) || m_second;
      if (rl) for (int k = 0; k < 16; k++) m_buf[k] = m_bank[k];
      m_second = !rl;
    end
    if (host_wr_en) m_bank[pos] = host_wr_data;
    exp_q = e; tag_q = t; pend = 1'b1;
  endtask

  task automatic run_t1(input bit esf, input int count, input bit rewrite);
    int nfr;
    int pos;
    nfr = esf ? 24 : 12;
    for (int m = 0; m < count; m++) begin
      seed++;
      for (int f = 1; f <= nfr; f++) begin
        drive_bit(f, 0, 0, 1'b1, f == 1, 0, rewrite);
        pos = 1;
        for (int c = 0; c < 24; c++)
          for (int b = 0; b < 8; b++) begin
            drive_bit(f, c, b, 1'b0, 1'b0, pos, rewrite);
            pos++;
          end
      end
    end
  endtask

  task automatic run_e1(input int count, input bit rewrite);
    int pos;
    for (int m = 0; m < count; m++) begin
      seed++;
      for (int f = 0; f < 16; f++) begin
        pos = 0;
        for (int t = 0; t < 32; t++)
          for (int b = 0; b < 8; b++) begin
            drive_bit(f, t, b, 1'b0, (f == 0 && t == 0 && b == 0), pos, rewrite);
            pos++;
          end
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; host_wr_en = 1'b0; host_wr_addr = '0; host_wr_data = '0;
    irq_clr = 1'b0; t1_mode = 1'b1; esf_mode = 1'b1; t1_ins_en = 1'b1;
    e1_ins_en = 1'b1; chan_ins_mask = '1; bit_vld = 1'b0; ser_in = 1'b0;
    fbit = 1'b0; mf_start = 1'b0; frame_num = '0; ts_num = '0; bit_num = '0;
    for (int k = 0; k < 16; k++) begin m_bank[k] = '0; m_buf[k] = '0; end
    m_second = 1'b1; pend = 1'b0; seed = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(ser_out == 1'b0, "R1", ser_out, 0);
    check(mf_irq == 1'b0, "R1", mf_irq, 0);

    for (int k = 0; k < 16; k++) host_write_idle(k, mkval(99, k));
    // R3, R2: full ESF multiframes with mid-multiframe rewrites
    run_t1(1'b1, 2, 1'b1);
    // R8: partial channel mask
    chan_ins_mask = 32'h00A5_5A3C;
    run_t1(1'b1, 1, 1'b1);
    // R4, R5: D4 pairs with a rewrite in every superframe
    chan_ins_mask = '1; esf_mode = 1'b0;
    run_t1(1'b0, 4, 1'b1);
    chan_ins_mask = 32'h0000_F0F0;
    run_t1(1'b0, 2, 1'b1);
    // R7: T1 global disable
    chan_ins_mask = '1; esf_mode = 1'b1; t1_ins_en = 1'b0;
    run_t1(1'b1, 1, 1'b0);
    // R6: E1 timeslot 16
    t1_mode = 1'b0; t1_ins_en = 1'b1;
    run_e1(2, 1'b1);
    chan_ins_mask = 32'h5A5A_A5A6;
    run_e1(1, 1'b1);
    // R7: E1 global disable
    chan_ins_mask = '1; e1_ins_en = 1'b0;
    run_e1(1, 1'b0);

    @(negedge clk);
    if (pend) check(ser_out == exp_q, tag_q, ser_out, exp_q);
    bit_vld = 1'b0;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule